// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is a 32-bit down-counter that paces itself from a programmable power-of-two clock divider. It raises a one-cycle interrupt request when the count runs out. Software programs three registers through a simple write port: a divide configuration, an initial count and a vector entry. Writing the initial count loads the counter and starts it. Writing it again abandons the running count and starts over from the new value. The live counter value is always visible on an output.

The vector entry holds an 8-bit interrupt vector, a mask bit and a periodic-mode bit. In one-shot mode the counter stays at zero after it expires. In periodic mode it reloads from the initial count and keeps running. The request is meant for an edge-triggered, fixed-delivery interrupt path. It carries the vector from the entry and is raised only while the software-enable input is high and the entry is unmasked. Dropping software enable forces the entry masked.

Top module: `irq_countdown_timer`

## Requirements
- R1: The divisor is 2^n with n = ({cfg[3], cfg[1], cfg[0]} + 1) mod 8. So cfg 4'b0000 divides by 2, 4'b1011 divides by 1 and 4'b1010 divides by 128, and cfg[2] has no effect on the divisor.
- R2: A write with wr_sel = 1 loads wr_data into the counter, cancels any running count, clears the divider phase and restarts the countdown. The next request comes exactly N × divisor cycles after the write edge.
- R3: In one-shot mode (entry bit 17 = 0) the counter reaches 0 on expiry and stays at 0, and no further request follows.
- R4: In periodic mode (entry bit 17 = 1) expiry reloads the counter from the initial count. Requests then repeat every N × divisor cycles.
- R5: On expiry irq_req pulses for one cycle and irq_vector carries entry bits [7:0]. This happens only if sw_enable is high and the mask bit (entry bit 16) is clear.
- R6: A write with wr_sel = 2 stores only the bits of mask 32'h0003_10FF: vector [7:0], delivery status [12], mask [16] and periodic [17]. All other bits read 0.
- R7: While sw_enable is low the entry's mask bit is set, and any entry write made while it is low is stored with the mask bit set.
- R8: After reset the entry reads 32'h0001_0000, the counter reads 0, irq_req is low and the divide configuration is 0, so the divisor is 2.
- R9: An initial count of 0 never produces a request, and the counter stays at 0.
- R10: cur_count shows the live counter value, which drops by exactly one per divided tick. The first drop comes one full divisor period after the load.
- R11: The write select uses 0 for the divide configuration, 1 for the initial count and 2 for the vector entry. Select 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_enable | input | 1 | Software enable for the interrupt unit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 divide, 1 initial count, 2 vector entry) |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Live counter value |
| lvt_entry | output | 32 | Stored vector entry |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector delivered with the request |

## Verification
The bench measures the exact cycle distance from the initial-count write to the request for every divide pattern. A decoder that used cfg[2], or that did not wrap 111 to divide-by-1, would show up as a wrong distance. A restart in mid-count must take its timing from the new write. A design that kept the old count would fire early. Periodic reload is checked by reading the counter in the cycle of the request and by timing the next request. An initial count of zero and a masked or disabled entry must stay silent. A design that let the zero count wrap would fire about 2^32 ticks later, which the bench does not wait for. A design that ignored the mask would raise a request the bench does not expect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    SEL_DIV   = 2'd0,
    SEL_INIT  = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_NONE  = 2'd3
  } tmr_sel_e;

  localparam int DIV_SHIFT_W  = 3;
  localparam int ENTRY_W      = 32;
  localparam int MASK_BIT     = 16;
  localparam int PERIODIC_BIT = 17;
  localparam logic [ENTRY_W-1:0] ENTRY_WMASK = 32'h0003_10FF;
  localparam logic [ENTRY_W-1:0] ENTRY_RESET = 32'h0001_0000;

  // power-of-two exponent selected by the divide configuration
  function automatic logic [DIV_SHIFT_W-1:0] div_shift(input logic [3:0] cfg);
    return {cfg[3], cfg[1], cfg[0]} + 3'd1;
  endfunction

  // value stored into the vector entry for a write
  function automatic logic [ENTRY_W-1:0] entry_merge(input logic [ENTRY_W-1:0] data,
                                                     input logic sw_en);
    logic [ENTRY_W-1:0] v;
    v = data & ENTRY_WMASK;
    if (!sw_en) v[MASK_BIT] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [3:0] div_cfg,
  output logic       tick
);
  localparam int PW = (1 << DIV_SHIFT_W) - 1;

  logic [DIV_SHIFT_W-1:0] shift_w;
  logic [PW:0]            span_w;
  logic [PW-1:0]          limit_w;
  logic [PW-1:0]          phase_q;

  assign shift_w = div_shift(div_cfg);
  assign span_w  = {{PW{1'b0}}, 1'b1} << shift_w;
  assign limit_w = span_w[PW-1:0] - 1'b1;
  assign tick    = (phase_q >= limit_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase_q <= '0;
    else if (clr)       phase_q <= '0;
    else if (tick)      phase_q <= '0;
    else                phase_q <= phase_q + 1'b1;
  end

  // R1: after a tick a new tick needs a full divisor period (unless divide-by-1)
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (!tick || limit_w == '0));

endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign count  = cnt_q;
  assign expire = !load && tick && run_q && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= (load_val != '0);
    end else if (expire) begin
      cnt_q <= periodic ? reload_val : '0;
      run_q <= periodic && (reload_val != '0);
    end else if (tick && run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3: a counter at zero stays at zero until loaded
  a_r3_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));

  // R10: without load or expiry the counter holds or drops by exactly one
  a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expire && cnt_q != '0) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));

  // R4: periodic expiry reloads the initial count
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (cnt_q == $past(reload_val)));

endmodule

// File: rtl/tmr_vec_entry.sv
module tmr_vec_entry
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_en,
  input  logic               wr,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic [ENTRY_W-1:0] entry
);
  logic [ENTRY_W-1:0] entry_q;

  assign entry = entry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       entry_q <= ENTRY_RESET;
    else if (wr)      entry_q <= entry_merge(wr_data, sw_en);
    else if (!sw_en)  entry_q[MASK_BIT] <= 1'b1;
  end

  // R7: software disable leaves the entry masked on the next cycle
  a_r7_forced_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> entry_q[MASK_BIT]);

  // R6: a write while enabled stores exactly the writable bits
  a_r6_write_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sw_en) |=> (entry_q == ($past(wr_data) & ENTRY_WMASK)));

endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_enable,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  output logic [CNT_W-1:0] cur_count,
  output logic [31:0]      lvt_entry,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector
);
  logic [3:0]       div_cfg_q;
  logic [CNT_W-1:0] init_q;
  logic             wr_div, wr_init, wr_entry;
  logic             tick, expire, fire;
  logic [31:0]      entry_w;

  assign wr_div   = wr_en && (tmr_sel_e'(wr_sel) == SEL_DIV);
  assign wr_init  = wr_en && (tmr_sel_e'(wr_sel) == SEL_INIT);
  assign wr_entry = wr_en && (tmr_sel_e'(wr_sel) == SEL_ENTRY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cfg_q <= '0;
      init_q    <= '0;
    end else begin
      if (wr_div)  div_cfg_q <= wr_data[3:0];
      if (wr_init) init_q    <= wr_data[CNT_W-1:0];
    end
  end

  tmr_prescale u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (wr_init),
    .div_cfg (div_cfg_q),
    .tick    (tick)
  );

  tmr_downcount #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (wr_init),
    .load_val   (wr_data[CNT_W-1:0]),
    .reload_val (init_q),
    .tick       (tick),
    .periodic   (entry_w[PERIODIC_BIT]),
    .count      (cur_count),
    .expire     (expire)
  );

  tmr_vec_entry u_entry (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_en   (sw_enable),
    .wr      (wr_entry),
    .wr_data (wr_data),
    .entry   (entry_w)
  );

  assign lvt_entry = entry_w;
  assign fire      = expire && sw_enable && !entry_w[MASK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req    <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_req    <= fire;
      irq_vector <= entry_w[VEC_W-1:0];
    end
  end

  // R5: a request only follows an expiry seen while enabled and unmasked
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($past(expire) && $past(sw_enable) && !$past(entry_w[MASK_BIT])));

  // R9: a zero initial count leaves no expiry behind it
  a_r9_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_init && wr_data[CNT_W-1:0] == '0) |=> !expire);

endmodule

// File: tb/test_irq_countdown_timer.sv
module test_irq_countdown_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_enable = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] cur_count;
  logic [31:0] lvt_entry;
  logic        irq_req;
  logic [7:0]  irq_vector;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  irq_countdown_timer i_irq_countdown_timer (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .cur_count(cur_count),
    .lvt_entry(lvt_entry), .irq_req(irq_req), .irq_vector(irq_vector)
  );

  // table: divide config, initial count, vector
  localparam int NV = 8;
  localparam logic [3:0]  T_CFG [NV] = '{4'b1011, 4'b0000, 4'b0001, 4'b0010,
                                         4'b0011, 4'b1000, 4'b1010, 4'b0100};
  localparam logic [31:0] T_CNT [NV] = '{32'd5, 32'd3, 32'd2, 32'd3,
                                         32'd1, 32'd2, 32'd1, 32'd4};
  localparam logic [7:0]  T_VEC [NV] = '{8'h30, 8'h31, 8'h42, 8'h5F,
                                         8'h60, 8'h7A, 8'hE3, 8'hFF};

  function automatic int divisor_of(input logic [3:0] c);
    case ({c[3], c[1], c[0]})
      3'b000: return 2;
      3'b001: return 4;
      3'b010: return 8;
      3'b011: return 16;
      3'b100: return 32;
      3'b101: return 64;
      3'b110: return 128;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_irq(input int limit, output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!irq_req && cyc < limit);
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_req) seen++;
    end
    chk(req, seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 count", cur_count, 32'd0);
    chk("R8 entry", lvt_entry, 32'h0001_0000);
    chk("R8 irq", {31'd0, irq_req}, 32'd0);
    rst_n = 1'b1;
    sw_enable = 1'b1;
    @(negedge clk);

    // R8/R1: default divide config divides by 2
    wr(2'd2, 32'h0000_0040);
    wr(2'd1, 32'd3);
    wait_irq(40, cyc);
    chk("R8 default divisor cycles", cyc, 32'd6);
    chk("R5 vector", {24'd0, irq_vector}, 32'h40);

    // R6: only writable bits stored
    wr(2'd2, 32'hFFFF_FFFF);
    chk("R6 entry bits", lvt_entry, 32'h0003_10FF);

    // R11: select 3 writes nothing
    wr(2'd3, 32'h0000_0000);
    chk("R11 select 3 entry", lvt_entry, 32'h0003_10FF);
    chk("R11 select 3 count", cur_count, 32'd0);

    // R1/R2/R3/R5: table of one-shot runs
    for (int k = 0; k < NV; k++) begin
      int exp_c;
      exp_c = int'(T_CNT[k]) * divisor_of(T_CFG[k]);
      wr(2'd0, {28'd0, T_CFG[k]});
      wr(2'd2, {24'd0, T_VEC[k]});
      wr(2'd1, T_CNT[k]);
      wait_irq(exp_c + 20, cyc);
      chk("R1 R2 expiry cycles", cyc, exp_c);
      chk("R5 vector", {24'd0, irq_vector}, {24'd0, T_VEC[k]});
      chk("R3 count at zero", cur_count, 32'd0);
      @(negedge clk);
      chk("R5 single-cycle pulse", {31'd0, irq_req}, 32'd0);
      quiet(20, "R3 no repeat");
      chk("R3 count holds zero", cur_count, 32'd0);
    end

    // R2: restart mid-count
    wr(2'd0, 32'h0000_000B);
    wr(2'd2, 32'h0000_0021);
    wr(2'd1, 32'd10);
    repeat (4) @(negedge clk);
    wr(2'd1, 32'd6);
    chk("R2 reload value", cur_count, 32'd6);
    wait_irq(40, cyc);
    chk("R2 restart cycles", cyc, 32'd6);

    // R10: live count, one step per divided tick (divide by 4)
    wr(2'd0, 32'h0000_0001);
    wr(2'd1, 32'd5);
    chk("R10 loaded", cur_count, 32'd5);
    repeat (3) @(negedge clk);
    chk("R10 before first tick", cur_count, 32'd5);
    @(negedge clk);
    chk("R10 first tick", cur_count, 32'd4);
    repeat (4) @(negedge clk);
    chk("R10 second tick", cur_count, 32'd3);

    // R9: initial count of zero
    wr(2'd1, 32'd0);
    chk("R9 count zero", cur_count, 32'd0);
    quiet(50, "R9 never fires");

    // R4: periodic reload, divide by 2, count 3
    wr(2'd0, 32'h0000_0000);
    wr(2'd2, 32'h0002_0077);
    wr(2'd1, 32'd3);
    wait_irq(40, cyc);
    chk("R4 first period", cyc, 32'd6);
    chk("R4 reloaded count", cur_count, 32'd3);
    chk("R4 vector", {24'd0, irq_vector}, 32'h77);
    wait_irq(40, cyc);
    chk("R4 second period", cyc, 32'd6);
    wait_irq(40, cyc);
    chk("R4 third period", cyc, 32'd6);
    wr(2'd1, 32'd0);

    // R5: masked entry gives no request
    wr(2'd0, 32'h0000_000B);
    wr(2'd2, 32'h0001_0011);
    wr(2'd1, 32'd3);
    quiet(10, "R5 masked silent");
    chk("R5 masked count expired", cur_count, 32'd0);

    // R7: software disable forces mask
    wr(2'd2, 32'h0000_0012);
    @(negedge clk);
    sw_enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 mask on disable", lvt_entry, 32'h0001_0012);
    wr(2'd2, 32'h0000_0055);
    chk("R7 write while disabled", lvt_entry, 32'h0001_0055);
    wr(2'd1, 32'd2);
    quiet(8, "R7 disabled silent");
    sw_enable = 1'b1;
    wr(2'd2, 32'h0000_0066);
    chk("R7 write after enable", lvt_entry, 32'h0000_0066);
    wr(2'd1, 32'd2);
    wait_irq(20, cyc);
    chk("R5 re-enabled cycles", cyc, 32'd2);
    chk("R5 re-enabled vector", {24'd0, irq_vector}, 32'h66);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule